// File: doc/BRIEF.md
# Link Destination Flow-Control Emulator

This block stands in for the receiving end of a 32-bit parallel data link so that a data source can be debugged without a real link. It runs on the user clock. It takes every word offered with an active-low write strobe. It keeps the most recent word and a flag that records whether that word was a control word, so a display or an analyser can read them. It drives the link-full and link-down indications back to the source, both active low, together with four return lines.

A four-bit selector picks where those outputs come from:

- fixed "always ready" values;
- a single-step state machine released by a pushbutton;
- a set of switch inputs;
- a pattern-generator port;
- two external pulse inputs.

The selector also sets how the block answers a link reset from the source. In the free-running mode it gives a link-down pulse of fixed length. In the single-step mode it holds link-down until the button is pressed.

The button, the switches, the pattern port and the external inputs are asynchronous to the user clock. All of them pass through a two-flop synchronizer. The data, write strobe, control flag and link-reset inputs arrive synchronous to the user clock and are used directly.

Top module: `link_dest_emu`

## Requirements
- R1: The selector decodes 0 as free-run, 1 as single-step, 2 as switches, 3 as pattern and 4 as external. Every other value, 5 to 15, behaves as free-run.
- R2: In free-run, with no link reset pending, `lff_n` and `ldown_n` are both 1, and `lrl` equals `sw_rl`.
- R3: In single-step, one clock edge that sees `uwen_n` low drives `lff_n` to 0 after that edge.
- R4: In single-step, `lff_n` stays 0 until a rising edge of `step_btn` is seen through the synchronizer; it is 1 again within five clocks of the press. Words written while `lff_n` is 0 are still taken, and each overwrites the held word.
- R5: In free-run, `ldown_n` is 0 for exactly six clock cycles after the last edge at which `ureset_n` was sampled low, then returns to 1.
- R6: In single-step, an edge that sees `ureset_n` low drives `ldown_n` to 0. It stays 0 until a rising edge of `step_btn` is seen.
- R7: In switches mode, `lff_n` follows `sw_full_n`, `ldown_n` follows `sw_down_n`, and `lrl` follows `sw_rl`.
- R8: In pattern mode, `lff_n` follows `pat_in[5]`, `ldown_n` follows `pat_in[4]`, and `lrl` follows `pat_in[3:0]`.
- R9: In external mode, `lff_n` follows `ext_full_n`, `ldown_n` follows `ext_down_n`, and `lrl` follows `sw_rl`.
- R10: On each edge with `uwen_n` low, `word_q` takes `ud` and `ctrl_word` takes the inverse of `uctrl_n`. Otherwise both hold their values, and a link reset on `ureset_n` leaves them unchanged.
- R11: After `rst`, `word_q` is 0, `ctrl_word` is 0, and in free-run `lff_n` and `ldown_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high block reset |
| mode_sel | input | 4 | Output-source selector |
| ud | input | 32 | Data word from the source |
| uwen_n | input | 1 | Active-low write strobe |
| uctrl_n | input | 1 | Active-low control-word flag |
| ureset_n | input | 1 | Active-low link reset from the source |
| step_btn | input | 1 | Single-step pushbutton (asynchronous) |
| sw_full_n | input | 1 | Switch value for link-full |
| sw_down_n | input | 1 | Switch value for link-down |
| sw_rl | input | 4 | Switch values for return lines |
| pat_in | input | 6 | Pattern port: [5] full, [4] down, [3:0] return lines |
| ext_full_n | input | 1 | External link-full input |
| ext_down_n | input | 1 | External link-down input |
| lff_n | output | 1 | Link full, active low |
| ldown_n | output | 1 | Link down, active low |
| lrl | output | 4 | Return lines |
| word_q | output | 32 | Last word written |
| ctrl_word | output | 1 | Last word written was a control word |

## Verification
The assertions assume that `mode_sel` is quasi-static: it changes only while the source is idle, and never in the same cycle as a write or a link reset that the check depends on. The bench changes the selector only between tests and waits several clocks before it drives anything else. The assertions also assume that the button and switch inputs stay steady for longer than the synchronizer depth. The bench holds each such input for at least four clocks, so every edge it produces is seen once.

// File: rtl/link_emu_pkg.sv
package link_emu_pkg;

    localparam int DATA_W      = 32;
    localparam int RL_W        = 4;
    localparam int SEL_W       = 4;
    localparam int PAT_W       = RL_W + 2;
    localparam int HOLD_CYCLES = 6;

    typedef enum logic [2:0] {
        MODE_RUN     = 3'd0,
        MODE_STEP    = 3'd1,
        MODE_SWITCH  = 3'd2,
        MODE_PATTERN = 3'd3,
        MODE_EXTERN  = 3'd4
    } mode_e;

    typedef struct packed {
        logic            full_n;
        logic            down_n;
        logic [RL_W-1:0] rl;
    } flow_t;

    function automatic mode_e decode_mode(input logic [SEL_W-1:0] sel);
        case (sel)
            4'd1:    return MODE_STEP;
            4'd2:    return MODE_SWITCH;
            4'd3:    return MODE_PATTERN;
            4'd4:    return MODE_EXTERN;
            default: return MODE_RUN;
        endcase
    endfunction

endpackage

// File: rtl/emu_sync.sv
module emu_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/emu_run_timer.sv
module emu_run_timer #(
    parameter int HOLD = link_emu_pkg::HOLD_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic link_rst,
    output logic down_n
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= '0;
        else if (run && link_rst) cnt <= HOLD_V;
        else if (cnt != '0)       cnt <= cnt - 1'b1;
    end

    assign down_n = (cnt == '0);

    assert_run_down_R5: assert property (@(posedge clk) disable iff (rst)
        (run && link_rst) |=> !down_n);
    assert_run_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (down_n && !(run && link_rst)) |=> down_n);
endmodule

// File: rtl/emu_step_ctrl.sv
module emu_step_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic word_in,
    input  logic link_rst,
    input  logic step_pulse,
    output logic full_n,
    output logic down_n
);
    logic full_q, down_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            full_q <= 1'b0;
            down_q <= 1'b0;
        end else begin
            if (word_in)         full_q <= 1'b1;
            else if (step_pulse) full_q <= 1'b0;
            if (link_rst)        down_q <= 1'b1;
            else if (step_pulse) down_q <= 1'b0;
        end
    end

    assign full_n = ~full_q;
    assign down_n = ~down_q;

    assert_step_full_R3: assert property (@(posedge clk) disable iff (rst)
        (active && word_in) |=> !full_n);
    assert_step_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (active && !full_n && !step_pulse) |=> !full_n);
    assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !down_n && !step_pulse) |=> !down_n);
endmodule

// File: rtl/emu_word_latch.sv
module emu_word_latch #(
    parameter int W = link_emu_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] data,
    input  logic         is_ctrl,
    output logic [W-1:0] word_q,
    output logic         ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            ctrl_q <= 1'b0;
        end else if (wr) begin
            word_q <= data;
            ctrl_q <= is_ctrl;
        end
    end

    assert_store_R10: assert property (@(posedge clk) disable iff (rst)
        wr |=> (word_q == $past(data)) && (ctrl_q == $past(is_ctrl)));
    assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(word_q) && $stable(ctrl_q));
endmodule

// File: rtl/link_dest_emu.sv
module link_dest_emu
    import link_emu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  mode_sel,
    input  logic [DATA_W-1:0] ud,
    input  logic              uwen_n,
    input  logic              uctrl_n,
    input  logic              ureset_n,
    input  logic              step_btn,
    input  logic              sw_full_n,
    input  logic              sw_down_n,
    input  logic [RL_W-1:0]   sw_rl,
    input  logic [PAT_W-1:0]  pat_in,
    input  logic              ext_full_n,
    input  logic              ext_down_n,
    output logic              lff_n,
    output logic              ldown_n,
    output logic [RL_W-1:0]   lrl,
    output logic [DATA_W-1:0] word_q,
    output logic              ctrl_word
);
    localparam int ASYNC_W = 1 + 2 + RL_W + PAT_W + 2;

    logic [ASYNC_W-1:0] async_raw, async_s;
    logic               btn_s, btn_d, step_pulse;
    logic               swf_s, swd_s, exf_s, exd_s;
    logic [RL_W-1:0]    swrl_s;
    logic [PAT_W-1:0]   pat_s;
    mode_e              mode;
    logic               run_down_n, step_full_n, step_down_n;
    flow_t              sel;

    assign async_raw = {step_btn, sw_full_n, sw_down_n, sw_rl, pat_in, ext_full_n, ext_down_n};

    emu_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(async_raw), .dout(async_s)
    );

    assign {btn_s, swf_s, swd_s, swrl_s, pat_s, exf_s, exd_s} = async_s;

    always_ff @(posedge clk) begin
        if (rst) btn_d <= 1'b0;
        else     btn_d <= btn_s;
    end
    assign step_pulse = btn_s & ~btn_d;

    assign mode = decode_mode(mode_sel);

    emu_run_timer #(.HOLD(HOLD_CYCLES)) u_run (
        .clk(clk), .rst(rst), .run(mode == MODE_RUN),
        .link_rst(~ureset_n), .down_n(run_down_n)
    );

    emu_step_ctrl u_step (
        .clk(clk), .rst(rst), .active(mode == MODE_STEP),
        .word_in(~uwen_n), .link_rst(~ureset_n), .step_pulse(step_pulse),
        .full_n(step_full_n), .down_n(step_down_n)
    );

    emu_word_latch #(.W(DATA_W)) u_word (
        .clk(clk), .rst(rst), .wr(~uwen_n), .data(ud),
        .is_ctrl(~uctrl_n), .word_q(word_q), .ctrl_q(ctrl_word)
    );

    always_comb begin
        sel = '{full_n: 1'b1, down_n: run_down_n, rl: swrl_s};
        case (mode)
            MODE_STEP:    sel = '{full_n: step_full_n, down_n: step_down_n, rl: swrl_s};
            MODE_SWITCH:  sel = '{full_n: swf_s, down_n: swd_s, rl: swrl_s};
            MODE_PATTERN: sel = '{full_n: pat_s[PAT_W-1], down_n: pat_s[PAT_W-2], rl: pat_s[RL_W-1:0]};
            MODE_EXTERN:  sel = '{full_n: exf_s, down_n: exd_s, rl: swrl_s};
            default:      ;
        endcase
    end

    assign lff_n   = sel.full_n;
    assign ldown_n = sel.down_n;
    assign lrl     = sel.rl;

    assert_run_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN) |-> lff_n);
    assert_unused_sel_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_sel > 4'd4) |-> lff_n);
endmodule

// File: tb/tb_link_dest_emu.sv
module tb_link_dest_emu;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  mode_sel;
    logic [31:0] ud;
    logic        uwen_n, uctrl_n, ureset_n, step_btn;
    logic        sw_full_n, sw_down_n, ext_full_n, ext_down_n;
    logic [3:0]  sw_rl;
    logic [5:0]  pat_in;
    logic        lff_n, ldown_n, ctrl_word;
    logic [3:0]  lrl;
    logic [31:0] word_q;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    link_dest_emu dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ud(ud), .uwen_n(uwen_n),
        .uctrl_n(uctrl_n), .ureset_n(ureset_n), .step_btn(step_btn),
        .sw_full_n(sw_full_n), .sw_down_n(sw_down_n), .sw_rl(sw_rl),
        .pat_in(pat_in), .ext_full_n(ext_full_n), .ext_down_n(ext_down_n),
        .lff_n(lff_n), .ldown_n(ldown_n), .lrl(lrl), .word_q(word_q),
        .ctrl_word(ctrl_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] d, input logic ctl_n);
        ud = d; uctrl_n = ctl_n; uwen_n = 1'b0;
        @(negedge clk);
        uwen_n = 1'b1; uctrl_n = 1'b1;
    endtask

    task automatic press;
        step_btn = 1'b1; ticks(5);
    endtask

    task automatic release_btn;
        step_btn = 1'b0; ticks(4);
    endtask

    // mode, swf, swd, swrl, pat, exf, exd | lff, ldown, lrl
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        {4'd0, 1'b0, 1'b0, 4'hA, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'hA},
        {4'd2, 1'b0, 1'b1, 4'h5, 6'h3F, 1'b1, 1'b0, 1'b0, 1'b1, 4'h5},
        {4'd2, 1'b1, 1'b0, 4'h3, 6'h30, 1'b0, 1'b1, 1'b1, 1'b0, 4'h3},
        {4'd3, 1'b0, 1'b1, 4'hF, 6'b101001, 1'b0, 1'b1, 1'b1, 1'b0, 4'h9},
        {4'd3, 1'b1, 1'b0, 4'h0, 6'b010110, 1'b1, 1'b0, 1'b0, 1'b1, 4'h6},
        {4'd4, 1'b1, 1'b1, 4'hC, 6'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'hC},
        {4'd4, 1'b0, 1'b1, 4'h7, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, 4'h7},
        {4'd7, 1'b0, 1'b0, 4'h2, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'h2},
        {4'd9, 1'b0, 1'b0, 4'h4, 6'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 4'h4}
    };

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; mode_sel = 4'd0; ud = '0; uwen_n = 1'b1; uctrl_n = 1'b1;
        ureset_n = 1'b1; step_btn = 1'b0; sw_full_n = 1'b1; sw_down_n = 1'b1;
        sw_rl = 4'h0; pat_in = '0; ext_full_n = 1'b1; ext_down_n = 1'b1;
        ticks(3);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 word", word_q, 32'h0);
        check("R11 ctrl", {31'b0, ctrl_word}, 32'h0);
        check("R11 lff", {31'b0, lff_n}, 32'h1);
        check("R11 ldown", {31'b0, ldown_n}, 32'h1);

        // Static source table: R1 R2 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            {mode_sel, sw_full_n, sw_down_n, sw_rl, pat_in, ext_full_n, ext_down_n} = VEC[v][23:6];
            ticks(4);
            check($sformatf("R1/R2/R7/R8/R9 vec%0d lff", v), {31'b0, lff_n}, {31'b0, VEC[v][5]});
            check($sformatf("R1/R2/R7/R8/R9 vec%0d ldown", v), {31'b0, ldown_n}, {31'b0, VEC[v][4]});
            check($sformatf("R1/R2/R7/R8/R9 vec%0d lrl", v), {28'b0, lrl}, {28'b0, VEC[v][3:0]});
        end

        // R10 write and hold
        mode_sel = 4'd0; sw_rl = 4'h1; ticks(4);
        write_word(32'hDEAD_BEEF, 1'b0);
        check("R10 word", word_q, 32'hDEAD_BEEF);
        check("R10 ctrl", {31'b0, ctrl_word}, 32'h1);
        ud = 32'h1234_5678; ticks(3);
        check("R10 hold", word_q, 32'hDEAD_BEEF);

        // R5 free-run link reset pulse, R10 reset leaves word
        ureset_n = 1'b0; @(negedge clk); ureset_n = 1'b1;
        check("R5 low0", {31'b0, ldown_n}, 32'h0);
        for (int k = 1; k < 6; k++) begin
            @(negedge clk);
            check($sformatf("R5 low%0d", k), {31'b0, ldown_n}, 32'h0);
        end
        @(negedge clk);
        check("R5 release", {31'b0, ldown_n}, 32'h1);
        check("R10 link reset keeps word", word_q, 32'hDEAD_BEEF);
        check("R10 link reset keeps ctrl", {31'b0, ctrl_word}, 32'h1);
        // held reset: pulse counts from the last sampled low
        ureset_n = 1'b0; ticks(3); ureset_n = 1'b1;
        ticks(5);
        check("R5 held low", {31'b0, ldown_n}, 32'h0);
        @(negedge clk);
        check("R5 held release", {31'b0, ldown_n}, 32'h1);

        // R3 R4 single step
        mode_sel = 4'd1; ticks(4);
        check("R3 idle ready", {31'b0, lff_n}, 32'h1);
        write_word(32'h0000_00A1, 1'b1);
        check("R3 full after word", {31'b0, lff_n}, 32'h0);
        check("R10 step word", word_q, 32'h0000_00A1);
        write_word(32'h0000_00B2, 1'b1);
        write_word(32'h0000_00C3, 1'b0);
        check("R4 trailing word", word_q, 32'h0000_00C3);
        check("R4 trailing ctrl", {31'b0, ctrl_word}, 32'h1);
        ticks(6);
        check("R4 stays full", {31'b0, lff_n}, 32'h0);
        press();
        check("R4 released", {31'b0, lff_n}, 32'h1);
        ticks(6);
        check("R4 one step only", {31'b0, lff_n}, 32'h1);
        release_btn();
        check("R4 release no effect", {31'b0, lff_n}, 32'h1);

        // R6 single-step link reset
        ureset_n = 1'b0; @(negedge clk); ureset_n = 1'b1;
        check("R6 down", {31'b0, ldown_n}, 32'h0);
        ticks(12);
        check("R6 holds", {31'b0, ldown_n}, 32'h0);
        press();
        check("R6 released", {31'b0, ldown_n}, 32'h1);
        release_btn();

        done = 1'b1;
        finish_run();
    end
endmodule